// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the address and transfer-count state of one DMA channel. It turns that state into a 24-bit physical address for every transfer cycle. A page register supplies the upper address bits. A 16-bit current-address counter supplies the lower bits. Each accepted transfer increments the address and decrements the count. The block raises a one-cycle terminal-count pulse after the last transfer of a block.

The `WORD_MODE` parameter selects the variant at build time:

- **Byte channel:** the page and the counter are placed side by side, so a transfer stays inside a 64 KiB window.
- **Word channel:** the counter is shifted up by one bit, page bit 0 is dropped and address bit 0 is always zero, so a transfer stays inside a 128 KiB window.

The address counter never carries into the page, so the upper address bits stay fixed for the whole transfer.

The count is loaded as the number of transfers minus one. On terminal count the block does one of two things:

- **Auto-initialize set:** the current address and count reload from their base copies, and the channel keeps running.
- **Auto-initialize clear:** the channel masks itself.

Request arbitration, host register decode and bus handshakes belong to neighbouring logic.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the channel is masked, the terminal-count pulse is low, the current count is 0x0000 and the physical address is 0x000000.
- R2: With WORD_MODE=0 the physical address equals {page[7:0], current address[15:0]}.
- R3: With WORD_MODE=1 the physical address equals {page[7:1], current address[15:0], 1'b0}; page bit 0 has no effect and address bit 0 is always 0.
- R4: Each accepted transfer adds one to the current address modulo 65536, and the page-derived upper bits of the physical address never change as a result.
- R5: Each accepted transfer subtracts one from the current count. Terminal count (`tc` high for the one cycle after the edge) occurs on the transfer accepted while the count is 0x0000, that is, after exactly loaded count + 1 transfers.
- R6: On terminal count with `auto_init` high, the current address and count reload from the base values, and the channel stays unmasked.
- R7: On terminal count with `auto_init` low, the channel becomes masked, and the current count reads 0xFFFF.
- R8: `load_base` writes both the base and the current address and count. It takes priority over a transfer strobe in the same cycle.
- R9: While masked, `xfer_stb` has no effect on the current address or count.
- R10: `unmask` clears the mask from the next cycle on, unless a terminal count without auto-initialize masks the channel in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_base | input | 1 | Load base and current address and count |
| base_addr_in | input | 16 | Start address (word address on word channels) |
| base_cnt_in | input | 16 | Transfers minus one |
| page_we | input | 1 | Write the page register |
| page_in | input | 8 | Page value |
| auto_init | input | 1 | Reload on terminal count instead of masking |
| unmask | input | 1 | Clear the channel mask |
| xfer_stb | input | 1 | One transfer cycle completed |
| phys_addr | output | 24 | Physical address of the current transfer |
| cur_cnt | output | 16 | Remaining transfers minus one |
| masked | output | 1 | Channel mask state |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bench builds two copies side by side: one with WORD_MODE=0 and one with WORD_MODE=1. Both are driven by the same stimulus. Any page or address pattern can therefore be compared across the two address mappings in the same cycle. One case is an odd page value with the counter crossing 0xFFFF. It shows that the byte channel keeps page bit 0 while the word channel drops it, and that neither channel carries into the page.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
    parameter int CNT_W  = 16;
    parameter int PAGE_W = 8;
    localparam int PHYS_W = CNT_W + PAGE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  base_addr;
        logic [CNT_W-1:0]  cur_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [CNT_W-1:0]  cur_cnt;
        logic [PAGE_W-1:0] page;
        logic              mask;
        logic              tc;
    } chan_state_t;
endpackage

// File: rtl/dma_cnt_step.sv
module dma_cnt_step
    import dma_eng_pkg::*;
(
    input  logic [CNT_W-1:0] addr_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] addr_nxt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Address wraps inside the 16-bit counter; no carry leaves this module.
    assign addr_nxt = addr_in + ONE;
    assign cnt_nxt  = cnt_in - ONE;
    assign last     = (cnt_in == '0);
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
    import dma_eng_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [CNT_W-1:0]  addr,
    output logic [PHYS_W-1:0] phys
);
    generate
        if (WORD_MODE) begin : g_word
            assign phys = {page[PAGE_W-1:1], addr, 1'b0};
        end else begin : g_byte
            assign phys = {page, addr};
        end
    endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [CNT_W-1:0]  base_addr_in,
    input  logic [CNT_W-1:0]  base_cnt_in,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              auto_init,
    input  logic              unmask,
    input  logic              xfer_stb,
    output chan_state_t       st
);
    chan_state_t       st_d, st_q;
    logic [CNT_W-1:0]  addr_nxt, cnt_nxt;
    logic              last;

    dma_cnt_step u_step (
        .addr_in (st_q.cur_addr),
        .cnt_in  (st_q.cur_cnt),
        .addr_nxt(addr_nxt),
        .cnt_nxt (cnt_nxt),
        .last    (last)
    );

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (page_we) begin
            st_d.page = page_in;
        end
        if (unmask) begin
            st_d.mask = 1'b0;
        end
        if (load_base) begin
            st_d.base_addr = base_addr_in;
            st_d.cur_addr  = base_addr_in;
            st_d.base_cnt  = base_cnt_in;
            st_d.cur_cnt   = base_cnt_in;
        end else if (xfer_stb && !st_q.mask) begin
            st_d.cur_addr = addr_nxt;
            st_d.cur_cnt  = cnt_nxt;
            if (last) begin
                st_d.tc = 1'b1;
                if (auto_init) begin
                    st_d.cur_addr = st_q.base_addr;
                    st_d.cur_cnt  = st_q.base_cnt;
                end else begin
                    st_d.mask = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [CNT_W-1:0]  base_addr_in,
    input  logic [CNT_W-1:0]  base_cnt_in,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              auto_init,
    input  logic              unmask,
    input  logic              xfer_stb,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              masked,
    output logic              tc
);
    chan_state_t st;

    dma_chan_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_base   (load_base),
        .base_addr_in(base_addr_in),
        .base_cnt_in (base_cnt_in),
        .page_we     (page_we),
        .page_in     (page_in),
        .auto_init   (auto_init),
        .unmask      (unmask),
        .xfer_stb    (xfer_stb),
        .st          (st)
    );

    dma_phys_map #(.WORD_MODE(WORD_MODE)) u_map (
        .page(st.page),
        .addr(st.cur_addr),
        .phys(phys_addr)
    );

    assign cur_cnt = st.cur_cnt;
    assign masked  = st.mask;
    assign tc      = st.tc;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
    import dma_eng_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_base,
    input logic              page_we,
    input logic              auto_init,
    input logic              unmask,
    input logic              xfer_stb,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              masked,
    input logic              tc
);
    localparam int UP_LO = WORD_MODE ? CNT_W + 1 : CNT_W;

    logic go;
    assign go = xfer_stb && !masked && !load_base;

    // R3
    word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        WORD_MODE |-> (phys_addr[0] == 1'b0));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !page_we) |=> $stable(phys_addr[PHYS_W-1:UP_LO]));

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    // R5
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> ($past(xfer_stb) && !$past(masked) && $past(cur_cnt) == '0));

    // R7
    tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cur_cnt == '0 && !auto_init) |=> (masked && tc));

    // R9
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !load_base) |=> $stable(cur_cnt));

    // R10
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask && !(go && cur_cnt == '0 && !auto_init)) |=> !masked);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.WORD_MODE(WORD_MODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_base(load_base),
    .page_we  (page_we),
    .auto_init(auto_init),
    .unmask   (unmask),
    .xfer_stb (xfer_stb),
    .phys_addr(phys_addr),
    .cur_cnt  (cur_cnt),
    .masked   (masked),
    .tc       (tc)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_base = 1'b0;
    logic [15:0] base_addr_in = '0;
    logic [15:0] base_cnt_in = '0;
    logic        page_we = 1'b0;
    logic [7:0]  page_in = '0;
    logic        auto_init = 1'b0;
    logic        unmask = 1'b0;
    logic        xfer_stb = 1'b0;
    logic [23:0] phys_b, phys_w;
    logic [15:0] cnt_b, cnt_w;
    logic        masked_b, masked_w, tc_b, tc_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] pg;

    always #5 clk = ~clk;

    dma_xfer_engine #(.WORD_MODE(1'b0)) u_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .load_base(load_base), .base_addr_in(base_addr_in),
        .base_cnt_in(base_cnt_in), .page_we(page_we), .page_in(page_in),
        .auto_init(auto_init), .unmask(unmask), .xfer_stb(xfer_stb),
        .phys_addr(phys_b), .cur_cnt(cnt_b), .masked(masked_b), .tc(tc_b));

    dma_xfer_engine #(.WORD_MODE(1'b1)) u_dma_xfer_engine_w (
        .clk(clk), .rst_n(rst_n), .load_base(load_base), .base_addr_in(base_addr_in),
        .base_cnt_in(base_cnt_in), .page_we(page_we), .page_in(page_in),
        .auto_init(auto_init), .unmask(unmask), .xfer_stb(xfer_stb),
        .phys_addr(phys_w), .cur_cnt(cnt_w), .masked(masked_w), .tc(tc_w));

    function automatic logic [23:0] exp_byte(input logic [7:0] p, input logic [15:0] a);
        return (24'(p) << 16) | 24'(a);
    endfunction

    function automatic logic [23:0] exp_word(input logic [7:0] p, input logic [15:0] a);
        return ((24'(p) << 16) & 24'hFE0000) | (24'(a) << 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change at negedge; one negedge later the registered result is sampled.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        load_base = 0; page_we = 0; unmask = 0; xfer_stb = 0;
    endtask

    task automatic setup(input logic [7:0] p, input logic [15:0] a,
                         input logic [15:0] c, input logic ai);
        page_we = 1; page_in = p; load_base = 1; base_addr_in = a;
        base_cnt_in = c; auto_init = ai; unmask = 1;
        pg = p;
        tick();
        clear_inputs();
    endtask

    task automatic t_reset();
        chk("R1 masked", 32'(masked_b), 1);
        chk("R1 tc", 32'(tc_b), 0);
        chk("R1 cnt", 32'(cnt_b), 0);
        chk("R1 phys", 32'(phys_b), 0);
        chk("R1 phys word", 32'(phys_w), 0);
    endtask

    task automatic t_map_and_mask();
        page_we = 1; page_in = 8'h35; load_base = 1;
        base_addr_in = 16'h1234; base_cnt_in = 16'd5;
        tick();
        clear_inputs();
        chk("R2 byte map", 32'(phys_b), 32'(exp_byte(8'h35, 16'h1234)));
        chk("R3 word map", 32'(phys_w), 32'(exp_word(8'h35, 16'h1234)));
        xfer_stb = 1;
        tick(); tick();
        xfer_stb = 0;
        chk("R9 masked cnt", 32'(cnt_b), 5);
        chk("R9 masked addr", 32'(phys_b), 32'(exp_byte(8'h35, 16'h1234)));
        unmask = 1;
        tick();
        unmask = 0;
        chk("R10 unmask", 32'(masked_b), 0);
        xfer_stb = 1;
        tick();
        xfer_stb = 0;
        chk("R4 addr inc", 32'(phys_b), 32'(exp_byte(8'h35, 16'h1235)));
        chk("R3 word inc", 32'(phys_w), 32'(exp_word(8'h35, 16'h1235)));
        chk("R5 cnt dec", 32'(cnt_b), 4);
    endtask

    task automatic t_wrap();
        setup(8'h35, 16'hFFFE, 16'd4, 1'b0);
        xfer_stb = 1;
        tick();
        chk("R4 pre-wrap", 32'(phys_b), 32'(exp_byte(pg, 16'hFFFF)));
        tick();
        xfer_stb = 0;
        chk("R4 wrap byte", 32'(phys_b), 32'h350000);
        chk("R4 wrap word", 32'(phys_w), 32'h340000);
        chk("R3 word even", 32'(phys_w[0]), 0);
    endtask

    task automatic t_tc_noauto();
        setup(8'h02, 16'h0010, 16'd2, 1'b0);
        xfer_stb = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 tc timing", 32'(tc_b), (i == 2) ? 1 : 0);
        end
        chk("R7 masked on tc", 32'(masked_b), 1);
        chk("R7 cnt ffff", 32'(cnt_b), 32'hFFFF);
        tick();
        xfer_stb = 0;
        chk("R5 tc one cycle", 32'(tc_b), 0);
        chk("R9 ignored after tc", 32'(cnt_b), 32'hFFFF);
        chk("R9 addr held", 32'(phys_b), 32'(exp_byte(8'h02, 16'h0013)));
    endtask

    task automatic t_autoinit();
        setup(8'h07, 16'h0100, 16'd1, 1'b1);
        xfer_stb = 1;
        tick(); tick();
        chk("R6 tc", 32'(tc_b), 1);
        chk("R6 reload cnt", 32'(cnt_b), 1);
        chk("R6 reload addr", 32'(phys_b), 32'(exp_byte(8'h07, 16'h0100)));
        chk("R6 stays unmasked", 32'(masked_b), 0);
        tick();
        xfer_stb = 0;
        chk("R6 runs on", 32'(cnt_b), 0);
        chk("R6 tc low", 32'(tc_b), 0);
    endtask

    task automatic t_load_priority();
        setup(8'h01, 16'h4000, 16'd9, 1'b0);
        xfer_stb = 1; load_base = 1; base_addr_in = 16'h5000; base_cnt_in = 16'd20;
        tick();
        clear_inputs();
        chk("R8 load cnt", 32'(cnt_b), 20);
        chk("R8 load addr", 32'(phys_b), 32'(exp_byte(8'h01, 16'h5000)));
        chk("R8 word cnt", 32'(cnt_w), 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_map_and_mask();
        t_wrap();
        t_tc_noauto();
        t_autoinit();
        t_load_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule